// File: doc/BRIEF.md
# Regulator Start-Up and Fault Sequencer

This block is the digital supervisor of a step-down regulator. It takes the regulator from shutdown to regulation and back out again. When enabled, it first holds off switching for a fixed reference wake-up interval, counted in microsecond ticks. Next it runs a soft-start: the reference to the error amplifier is produced as a digital code that climbs one step at a time from zero to full scale. During this ramp the power stage is held in pulse-skipping operation, so an output that is already charged is not pulled down. After the ramp the sequencer holds the reference at full scale in the run state.

Three inputs force it out of normal operation. Dropping the enable or raising undervoltage lockout stops switching and closes the output-discharge switch. An over-temperature flag parks the sequencer in a fault state with everything off. A separate recovery flag, driven by a lower temperature threshold, restarts it directly through soft-start. While the regulator is switching and the short-circuit flag reports a feedback voltage below 0.2 V, the oscillator is told to run at one third of its nominal rate.

Top module: `reg_startup_seq`

## Requirements
- R1: After reset, the discharge switch is on and run, soft-start, force-skip, divide-by-three and the reference code are all 0.
- R2: With enable high and lockout low, the block leaves shutdown on the next clock. It keeps run, discharge, soft-start and the reference at 0 until exactly WAKE_US ticks have been taken in the wake state. Soft-start begins on the clock that takes the last of those ticks.
- R3: During soft-start, run, soft-start and force-skip are 1. The reference code starts at 0 and rises by exactly 1 on every STEP_TICKS-th tick taken in soft-start. It never falls.
- R4: On the clock after the code reaches full scale (2^CODE_W-1), the block enters run. Run is 1, soft-start and force-skip are 0, and the code stays at full scale.
- R5: The divide-by-three output equals the short-circuit flag in the same cycle while run is 1, and is 0 otherwise.
- R6: Enable low returns the block from any state to shutdown on the next clock: discharge 1, run 0, code 0.
- R7: Lockout high forces shutdown on the next clock and holds it while lockout stays high. Once it falls with enable high, the block begins a new wake interval.
- R8: Over-temperature while enabled puts the block in fault on the next clock: run, soft-start, discharge and code all 0. It stays there until recovery.
- R9: In fault, the recovery flag with over-temperature low restarts soft-start on the next clock with the code at 0 and no wake interval.
- R10: Shutdown takes priority over fault. When enable falls and over-temperature rises in the same cycle, the block shuts down. Enabling while over-temperature is high goes straight to fault.
- R11: The discharge switch is off in every state except shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Input undervoltage lockout flag |
| ot_i | input | 1 | Over-temperature flag (upper threshold) |
| ot_recover_i | input | 1 | Temperature recovered flag (lower threshold) |
| short_i | input | 1 | Feedback below short-circuit threshold |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| run_o | output | 1 | Power stage allowed to switch |
| ss_active_o | output | 1 | Soft-start ramp in progress |
| ref_code_o | output | CODE_W | Reference code to the ramp DAC |
| osc_div3_o | output | 1 | Oscillator at one third of nominal rate |
| force_skip_o | output | 1 | Force pulse-skipping operation |
| discharge_o | output | 1 | Output-discharge switch enable |

## Verification
Shutdown and thermal fault can be requested in the same cycle. The bench lowers enable and raises over-temperature on one falling edge while running. It requires discharge on, rather than the fault state, on the next cycle. It then enables with over-temperature still high and requires fault, with no wake or soft-start. A ramp step and a short-circuit fold-back can also coincide. The bench asserts the short flag during operation and requires divide-by-three in the same cycle without disturbing the code.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAKE  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_wake_timer.sv
module seq_wake_timer #(
  parameter int WAKE_US = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(WAKE_US + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_US - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = count_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!count_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R2: count stays inside the wake window
  p_wake_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/seq_ramp_gen.sv
module seq_ramp_gen #(
  parameter int CODE_W     = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o
);
  localparam int PRE_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_TICKS - 1);
  localparam logic [CODE_W-1:0] FULL     = '1;

  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] code_q;
  logic              step;

  assign step   = active_i && tick_i && (pre_q == PRE_LAST) && (code_q != FULL);
  assign code_o = code_q;
  assign full_o = (code_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (!active_i) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (tick_i) begin
      pre_q  <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (step) code_q <= code_q + 1'b1;
    end
  end

  // R3: ramp moves up by at most one step and never back while active
  p_ramp_mono_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |->
      (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));
  p_ramp_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(code_q) || !active_i || !$past(active_i));
endmodule

// File: rtl/reg_startup_seq.sv
module reg_startup_seq
  import seq_pkg::*;
#(
  parameter int WAKE_US    = 600,
  parameter int CODE_W     = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              uvlo_i,
  input  logic              ot_i,
  input  logic              ot_recover_i,
  input  logic              short_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              ss_active_o,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              osc_div3_o,
  output logic              force_skip_o,
  output logic              discharge_o
);
  localparam logic [CODE_W-1:0] FULL = '1;

  seq_state_e        st_q, st_d;
  logic              wake_done, ramp_full;
  logic [CODE_W-1:0] ramp_code;

  seq_wake_timer #(.WAKE_US(WAKE_US)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .count_i(st_q == ST_WAKE), .tick_i(tick_i), .done_o(wake_done)
  );

  seq_ramp_gen #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(st_q == ST_SOFT), .tick_i(tick_i),
    .code_o(ramp_code), .full_o(ramp_full)
  );

  always_comb begin
    st_d = st_q;
    if (!en_i || uvlo_i) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_OFF:   st_d = ot_i ? ST_FAULT : ST_WAKE;
        ST_WAKE:  if (ot_i) st_d = ST_FAULT; else if (wake_done) st_d = ST_SOFT;
        ST_SOFT:  if (ot_i) st_d = ST_FAULT; else if (ramp_full) st_d = ST_RUN;
        ST_RUN:   if (ot_i) st_d = ST_FAULT;
        ST_FAULT: if (ot_recover_i && !ot_i) st_d = ST_SOFT;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign run_o        = (st_q == ST_SOFT) || (st_q == ST_RUN);
  assign ss_active_o  = (st_q == ST_SOFT);
  assign force_skip_o = (st_q == ST_SOFT);
  assign discharge_o  = (st_q == ST_OFF);
  assign osc_div3_o   = run_o && short_i;
  assign ref_code_o   = (st_q == ST_RUN)  ? FULL :
                        (st_q == ST_SOFT) ? ramp_code : '0;

  p_disable_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (discharge_o && !run_o && ref_code_o == '0));
  p_uvlo_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (discharge_o && !run_o));
  p_fault_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uvlo_i && ot_i) |=> (!run_o && !discharge_o && ref_code_o == '0));
  p_ramp_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_active_o) |-> ref_code_o == '0);
  p_run_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ss_active_o) && run_o) |-> ($past(ref_code_o) == FULL && ref_code_o == FULL));
  p_no_discharge_on_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uvlo_i && !discharge_o) |=> !discharge_o || !en_i || uvlo_i || $past(!en_i || uvlo_i));
endmodule

// File: tb/tb_reg_startup_seq.sv
module tb_reg_startup_seq;
  localparam int WAKE_US = 6;
  localparam int CODE_W  = 4;
  localparam int STEP    = 2;
  localparam int FS      = (1 << CODE_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, uvlo_i = 0, ot_i = 0, ot_recover_i = 0, short_i = 0, tick_i = 0;
  logic run_o, ss_active_o, osc_div3_o, force_skip_o, discharge_o;
  logic [CODE_W-1:0] ref_code_o;

  int checks = 0, errors = 0, cyc = 0, tdiv = 0, ticks_total = 0;

  reg_startup_seq #(.WAKE_US(WAKE_US), .CODE_W(CODE_W), .STEP_TICKS(STEP)) dut (.*);

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_i <= (tdiv == 3);
  end

  always @(posedge clk_i) begin
    if (rst_ni && tick_i) ticks_total <= ticks_total + 1;
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_wake();
    int t0, n;
    t0 = ticks_total;
    n = 0;
    while (!ss_active_o && n < 200) begin
      check("R2 wake run", run_o, 0);
      check("R11 wake discharge", discharge_o, 0);
      check("R2 wake ref", int'(ref_code_o), 0);
      @(negedge clk_i);
      n++;
    end
    check("R2 wake length", ticks_total - t0, WAKE_US);
  endtask

  task automatic do_ramp();
    int ts, n, exp;
    ts = ticks_total;
    n = 0;
    while (ss_active_o && n < 500) begin
      exp = (ticks_total - ts) / STEP;
      if (exp > FS) exp = FS;
      check("R3 ramp code", int'(ref_code_o), exp);
      check("R3 force skip", force_skip_o, 1);
      check("R3 run", run_o, 1);
      @(negedge clk_i);
      n++;
    end
    check("R4 run", run_o, 1);
    check("R4 ss off", ss_active_o, 0);
    check("R4 skip off", force_skip_o, 0);
    check("R4 full", int'(ref_code_o), FS);
    check("R11 run discharge", discharge_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 discharge", discharge_o, 1);
    check("R1 run", run_o, 0);
    check("R1 ss", ss_active_o, 0);
    check("R1 skip", force_skip_o, 0);
    check("R1 div3", osc_div3_o, 0);
    check("R1 ref", int'(ref_code_o), 0);
  endtask

  task automatic t_startup();
    en_i = 1;
    @(negedge clk_i);
    check("R2 left shutdown", discharge_o, 0);
    do_wake();
    do_ramp();
  endtask

  task automatic t_short();
    short_i = 1;
    #1 check("R5 div3 running", osc_div3_o, 1);
    check("R5 ref unchanged", int'(ref_code_o), FS);
    @(negedge clk_i);
    short_i = 0;
    #1 check("R5 div3 released", osc_div3_o, 0);
  endtask

  task automatic t_fault();
    ot_i = 1;
    @(negedge clk_i);
    check("R8 run", run_o, 0);
    check("R8 discharge", discharge_o, 0);
    check("R8 ref", int'(ref_code_o), 0);
    check("R8 ss", ss_active_o, 0);
    ot_i = 0;
    repeat (5) @(negedge clk_i);
    check("R8 held", run_o, 0);
    ot_recover_i = 1;
    @(negedge clk_i);
    ot_recover_i = 0;
    check("R9 ss restart", ss_active_o, 1);
    check("R9 ref zero", int'(ref_code_o), 0);
    do_ramp();
  endtask

  task automatic t_uvlo();
    uvlo_i = 1;
    @(negedge clk_i);
    check("R7 discharge", discharge_o, 1);
    check("R7 run", run_o, 0);
    check("R7 ref", int'(ref_code_o), 0);
    repeat (5) @(negedge clk_i);
    check("R7 held", discharge_o, 1);
    short_i = 1;
    #1 check("R5 div3 off in shutdown", osc_div3_o, 0);
    short_i = 0;
    uvlo_i = 0;
    @(negedge clk_i);
    check("R7 rewake discharge", discharge_o, 0);
    check("R7 rewake ss", ss_active_o, 0);
    do_wake();
    do_ramp();
  endtask

  task automatic t_en_vs_ot();
    en_i = 0;
    ot_i = 1;
    @(negedge clk_i);
    check("R10 shutdown wins", discharge_o, 1);
    check("R10 run", run_o, 0);
    en_i = 1;
    @(negedge clk_i);
    check("R10 fault on enable", discharge_o, 0);
    check("R10 no soft-start", ss_active_o, 0);
    check("R10 run off", run_o, 0);
    ot_i = 0;
    repeat (3) @(negedge clk_i);
    check("R10 fault held", run_o, 0);
    ot_recover_i = 1;
    @(negedge clk_i);
    ot_recover_i = 0;
    check("R9 recover ss", ss_active_o, 1);
    do_ramp();
  endtask

  task automatic t_disable_midramp();
    en_i = 0;
    @(negedge clk_i);
    en_i = 1;
    @(negedge clk_i);
    do_wake();
    repeat (10) @(negedge clk_i);
    check("R6 in ramp", ss_active_o, 1);
    en_i = 0;
    @(negedge clk_i);
    check("R6 discharge", discharge_o, 1);
    check("R6 run", run_o, 0);
    check("R6 ref", int'(ref_code_o), 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_short();
    t_fault();
    t_uvlo();
    t_en_vs_ot();
    t_disable_midramp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule